// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block reduces the interrupt load of a receive path by merging frame-completion events into fewer CPU interrupts. It holds one coalescing channel for each receive queue. A channel counts completed frames and raises its interrupt when the count reaches that queue's programmable maximum. It also raises the interrupt when an idle timeout expires: the timeout restarts on every frame and is counted in line-rate serial ticks, which arrive as a one-cycle tick-enable. At 1000 Mb/s one tick covers 8 bits (125 MHz), at 100 Mb/s and 10 Mb/s one tick covers 4 bits (25 MHz and 2.5 MHz). Typical loads are 64 ticks at the two faster rates and 8 ticks at the slowest.

Each channel is a two-state machine. CH_IDLE means no frame is waiting. CH_GATHER means at least one frame has arrived since the last interrupt and the idle timer is running. The transitions are FIRST_FRAME (CH_IDLE to CH_GATHER on a frame when the maximum exceeds 1), COUNT_FULL (CH_GATHER to CH_IDLE when a frame brings the count to the maximum), TIMEOUT (CH_GATHER to CH_IDLE when the timer expires with no frame in that cycle), TIMEOUT_WITH_FRAME (CH_GATHER to CH_GATHER when expiry and a frame coincide) and MORE_FRAME (CH_GATHER to CH_GATHER on a frame below the maximum). A frame in CH_IDLE with a maximum of 0 or 1 fires at once and stays in CH_IDLE. Every firing sets a sticky pending flag for that queue. Software clears a flag by writing a one to it.

Configuration uses an opcode strobe and a 32-bit data word. Opcode 0x13 loads the shared timeout. Opcode 0x21 loads the maximum count of one queue.

Top module: `rx_coal_ctrl`

## Requirements
- R1: After reset every pending flag is 0 and `irq` is low. Every queue's maximum count is 4. The timeout is 0, which means off.
- R2: When a queue's frame count since its last interrupt reaches its maximum, the pending flag of that queue reads 1 in the cycle after the clock edge that sampled the frame.
- R3: A command with `cmd_op` = 0x21 loads `cmd_data[7:0]` as the maximum of the queue selected by `cmd_data[18:16]`. A maximum of 0 or 1 makes every frame fire at once.
- R4: A command with `cmd_op` = 0x13 loads `cmd_data[15:0]` as the timeout N, and the upper 16 bits are ignored. If frames are waiting below the maximum, the channel fires on the N-th tick after the cycle of the most recent frame.
- R5: Every frame restarts the timeout count of its queue. A tick in the same cycle as a frame is not counted.
- R6: A queue with no waiting frames never fires from the timer. A timeout of 0 turns off the timeout path.
- R7: If the timer expires in the same cycle that a frame completes, the channel fires once. That frame becomes the first frame of a new count, and its timer starts from zero.
- R8: A pending flag stays set until `irq_clr` carries a one on its bit. If a firing and a clear meet in the same cycle, the flag stays set.
- R9: `irq` equals the OR of all pending flags.
- R10: Queues count independently of one another. Commands with any other opcode change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse per serial-clock tick |
| frame_done | input | 8 | One-cycle pulse per queue when a frame completes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_data | input | 32 | Command data word |
| irq_clr | input | 8 | Write-one-to-clear for the pending flags |
| irq_pending | output | 8 | Sticky pending flag per queue |
| irq | output | 1 | OR of the pending flags |

## Verification
The assertions assume that a new pending flag can only follow a frame or a tick in the cycle before. They also assume that inputs are sampled only while reset is released, with `frame_done`, `tick_en` and `irq_clr` at zero during reset. The stimulus drives every input away from the active edge and returns the pulses to zero after each edge. It programs the timeout and the maximum counts only while the affected queues hold no waiting frames, so no check depends on a setting that changes in the middle of a count.

// File: rtl/rx_coal_pkg.sv
package rx_coal_pkg;
    typedef enum logic {
        CH_IDLE   = 1'b0,
        CH_GATHER = 1'b1
    } ch_state_e;

    localparam logic [7:0] OPC_SET_TMO = 8'h13;
    localparam logic [7:0] OPC_SET_MAX = 8'h21;
    localparam int         MAX_IDX_LSB = 16;
endpackage

// File: rtl/rx_coal_cfg.sv
module rx_coal_cfg
    import rx_coal_pkg::*;
#(
    parameter int NQ      = 8,
    parameter int CW      = 8,
    parameter int TW      = 16,
    parameter int DW      = 32,
    parameter int OPW     = 8,
    parameter int DEF_MAX = 4,
    parameter int DEF_TMO = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [OPW-1:0]           cmd_op,
    input  logic [DW-1:0]            cmd_data,
    output logic [TW-1:0]            tmo_val,
    output logic [NQ-1:0][CW-1:0]    max_val
);
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

    logic set_tmo;
    logic set_max;
    logic [QW-1:0] sel_q;

    assign set_tmo = cmd_valid && (cmd_op == OPW'(OPC_SET_TMO));
    assign set_max = cmd_valid && (cmd_op == OPW'(OPC_SET_MAX));
    assign sel_q   = cmd_data[MAX_IDX_LSB +: QW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_val <= TW'(DEF_TMO);
        end else if (set_tmo) begin
            tmo_val <= cmd_data[TW-1:0];
        end
    end

    for (genvar q = 0; q < NQ; q++) begin : g_max
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                max_val[q] <= CW'(DEF_MAX);
            end else if (set_max && (sel_q == QW'(q))) begin
                max_val[q] <= cmd_data[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/rx_coal_channel.sv
module rx_coal_channel
    import rx_coal_pkg::*;
#(
    parameter int CW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame,
    input  logic          tick_en,
    input  logic [CW-1:0] max_cnt,
    input  logic [TW-1:0] tmo,
    output logic          fire
);
    ch_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [CW:0]   cnt_inc;
    logic [TW:0]   tmr_inc;
    logic          expire;
    logic          one_shot;

    assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
    assign tmr_inc  = {1'b0, tmr_q} + 1'b1;
    assign one_shot = (max_cnt <= CW'(1));
    assign expire   = (state_q == CH_GATHER) && tick_en && (tmo != '0)
                      && (tmr_inc >= {1'b0, tmo});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tmr_q   <= tmr_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tmr_d   = tmr_q;
        fire    = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (frame) begin
                    if (one_shot) begin
                        fire = 1'b1;
                    end else begin
                        state_d = CH_GATHER;
                        cnt_d   = CW'(1);
                        tmr_d   = '0;
                    end
                end
            end
            CH_GATHER: begin
                if (frame && (cnt_inc >= {1'b0, max_cnt})) begin
                    fire    = 1'b1;
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                    tmr_d   = '0;
                end else if (expire) begin
                    fire  = 1'b1;
                    tmr_d = '0;
                    if (frame) begin
                        cnt_d = CW'(1);
                    end else begin
                        state_d = CH_IDLE;
                        cnt_d   = '0;
                    end
                end else if (frame) begin
                    cnt_d = cnt_inc[CW-1:0];
                    tmr_d = '0;
                end else if (tick_en && (tmr_q != '1)) begin
                    tmr_d = tmr_inc[TW-1:0];
                end
            end
            default: begin
                state_d = CH_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/rx_coal_pending.sv
module rx_coal_pending #(
    parameter int NQ = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] fire,
    input  logic [NQ-1:0] clr,
    output logic [NQ-1:0] pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr) | fire;
        end
    end
endmodule

// File: rtl/rx_coal_ctrl.sv
module rx_coal_ctrl #(
    parameter int NQ      = 8,
    parameter int CW      = 8,
    parameter int TW      = 16,
    parameter int DW      = 32,
    parameter int OPW     = 8,
    parameter int DEF_MAX = 4,
    parameter int DEF_TMO = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic [NQ-1:0]  frame_done,
    input  logic           cmd_valid,
    input  logic [OPW-1:0] cmd_op,
    input  logic [DW-1:0]  cmd_data,
    input  logic [NQ-1:0]  irq_clr,
    output logic [NQ-1:0]  irq_pending,
    output logic           irq
);
    logic [TW-1:0]         tmo_val;
    logic [NQ-1:0][CW-1:0] max_val;
    logic [NQ-1:0]         fire_vec;

    rx_coal_cfg #(
        .NQ(NQ), .CW(CW), .TW(TW), .DW(DW), .OPW(OPW),
        .DEF_MAX(DEF_MAX), .DEF_TMO(DEF_TMO)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_data (cmd_data),
        .tmo_val  (tmo_val),
        .max_val  (max_val)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_ch
        rx_coal_channel #(.CW(CW), .TW(TW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .frame  (frame_done[q]),
            .tick_en(tick_en),
            .max_cnt(max_val[q]),
            .tmo    (tmo_val),
            .fire   (fire_vec[q])
        );
    end

    rx_coal_pending #(.NQ(NQ)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire_vec),
        .clr  (irq_clr),
        .pend (irq_pending)
    );

    assign irq = |irq_pending;
endmodule

// File: rtl/rx_coal_chk.sv
module rx_coal_chk #(
    parameter int NQ = 8,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic [NQ-1:0] frame_done,
    input logic [NQ-1:0] irq_clr,
    input logic [NQ-1:0] irq_pending,
    input logic          irq,
    input logic [TW-1:0] tmo_val
);
    // R9
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|irq_pending));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(irq_pending) & ~irq_pending & ~$past(irq_clr)) == '0));

    // R2
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pending & ~$past(irq_pending)) != '0)
        |-> (($past(frame_done) != '0) || $past(tick_en)));

    // R6
    tmo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pending & ~$past(irq_pending) & ~$past(frame_done)) != '0)
        |-> ($past(tmo_val) != '0));
endmodule

bind rx_coal_ctrl rx_coal_chk #(.NQ(NQ), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .frame_done (frame_done),
    .irq_clr    (irq_clr),
    .irq_pending(irq_pending),
    .irq        (irq),
    .tmo_val    (tmo_val)
);

// File: tb/rx_coal_ctrl_test.sv
`timescale 1ns/1ps
module rx_coal_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  frame_done = '0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic [7:0]  irq_clr = '0;
    logic [7:0]  irq_pending;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    rx_coal_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .frame_done(frame_done),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .irq_clr(irq_clr), .irq_pending(irq_pending), .irq(irq)
    );

    // monitor: pops expectations and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                checks++;
                if (irq_pending !== it.val || irq !== (|it.val)) begin
                    errors++;
                    $display("FAIL %s: pending=%h irq=%b expected pending=%h irq=%b",
                             it.tag, irq_pending, irq, it.val, |it.val);
                end
            end
        end
    end

    task automatic push(input logic [7:0] ex, input string tag);
        exp_t it;
        it.val = ex;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic step(input logic [7:0] fr, input logic tk, input logic [7:0] clr,
                        input logic [7:0] ex, input string tag);
        @(negedge clk);
        frame_done = fr;
        tick_en    = tk;
        irq_clr    = clr;
        @(posedge clk);
        #1;
        frame_done = '0;
        tick_en    = 1'b0;
        irq_clr    = '0;
        push(ex, tag);
    endtask

    task automatic cmd(input logic [7:0] op, input logic [31:0] data,
                       input logic [7:0] ex, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        push(ex, tag);
    endtask

    task automatic ticks(input int n, input logic [7:0] ex, input string tag);
        for (int i = 0; i < n; i++) step(8'h00, 1'b1, 8'h00, ex, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        push(8'h00, "R1 reset state");
        rst_n = 1'b1;

        // R2: default maximum of 4
        for (int i = 0; i < 3; i++) step(8'h01, 1'b0, 8'h00, 8'h00, "R2 below max");
        step(8'h01, 1'b0, 8'h00, 8'h01, "R2 count reaches max");
        step(8'h00, 1'b0, 8'h01, 8'h00, "R8 write-one clear");

        // R6: timeout 0 after reset, so ticks never fire (R1 default)
        for (int i = 0; i < 3; i++) step(8'h02, 1'b0, 8'h00, 8'h00, "R6 frames q1");
        ticks(40, 8'h00, "R6 timeout off");
        step(8'h02, 1'b0, 8'h00, 8'h02, "R2 q1 reaches max");
        step(8'h00, 1'b0, 8'h02, 8'h00, "R8 clear q1");

        // R4: timeout 5, upper data bits ignored
        cmd(8'h13, 32'hABCD_0005, 8'h00, "R4 load timeout");
        ticks(20, 8'h00, "R6 no waiting frames");
        step(8'h04, 1'b0, 8'h00, 8'h00, "R4 frame q2");
        ticks(4, 8'h00, "R4 before expiry");
        step(8'h00, 1'b1, 8'h00, 8'h04, "R4 expiry on fifth tick");

        // R5: a frame restarts the timer; a tick with the frame is not counted
        step(8'h08, 1'b0, 8'h00, 8'h04, "R5 frame q3");
        ticks(3, 8'h04, "R5 partial wait");
        step(8'h08, 1'b1, 8'h00, 8'h04, "R5 restart frame");
        ticks(4, 8'h04, "R5 restarted wait");
        step(8'h00, 1'b1, 8'h00, 8'h0C, "R5 expiry after restart");
        step(8'h00, 1'b0, 8'h0C, 8'h00, "R8 clear q2 q3");

        // R7: expiry and frame coincide
        step(8'h20, 1'b0, 8'h00, 8'h00, "R7 frame q5");
        ticks(4, 8'h00, "R7 wait");
        step(8'h20, 1'b1, 8'h00, 8'h20, "R7 coincident single fire");
        step(8'h00, 1'b0, 8'h20, 8'h00, "R7 clear");
        ticks(4, 8'h00, "R7 frame counted, timer restarted");
        step(8'h00, 1'b1, 8'h00, 8'h20, "R7 second expiry");
        step(8'h00, 1'b0, 8'h20, 8'h00, "R8 clear q5");

        // R3: per-queue maximum, queue 4
        cmd(8'h21, 32'h0004_0001, 8'h00, "R3 max 1 on q4");
        step(8'h10, 1'b0, 8'h00, 8'h10, "R3 max 1 fires at once");
        step(8'h00, 1'b0, 8'h10, 8'h00, "R8 clear q4");
        cmd(8'h21, 32'h0004_0002, 8'h00, "R3 max 2 on q4");
        step(8'h10, 1'b0, 8'h00, 8'h00, "R3 max 2 first frame");
        step(8'h10, 1'b0, 8'h00, 8'h10, "R3 max 2 second frame");
        step(8'h00, 1'b0, 8'h10, 8'h00, "R8 clear q4 again");

        // R8: firing and clearing together keep the flag
        for (int i = 0; i < 3; i++) step(8'h40, 1'b0, 8'h00, 8'h00, "R8 frames q6");
        step(8'h40, 1'b0, 8'h00, 8'h40, "R2 q6 max");
        for (int i = 0; i < 3; i++) step(8'h40, 1'b0, 8'h00, 8'h40, "R8 flag sticky");
        step(8'h40, 1'b0, 8'h40, 8'h40, "R8 set wins over clear");
        step(8'h00, 1'b0, 8'h40, 8'h00, "R8 clear q6");

        // R10: unknown opcode leaves the timeout at 5
        cmd(8'h05, 32'h0000_0001, 8'h00, "R10 unknown opcode");
        step(8'h80, 1'b0, 8'h00, 8'h00, "R10 frame q7");
        ticks(4, 8'h00, "R10 timeout unchanged");
        step(8'h00, 1'b1, 8'h00, 8'h80, "R10 expiry at five");
        step(8'h00, 1'b0, 8'h80, 8'h00, "R8 clear q7");

        // R10: all queues together, q4 has max 2
        step(8'hFF, 1'b0, 8'h00, 8'h00, "R10 all queues 1");
        step(8'hFF, 1'b0, 8'h00, 8'h10, "R10 q4 alone at 2");
        step(8'hFF, 1'b0, 8'h00, 8'h10, "R10 all queues 3");
        step(8'hFF, 1'b0, 8'h00, 8'hFF, "R10 all queues at 4");
        step(8'h00, 1'b0, 8'hFF, 8'h00, "R9 irq drops after clear");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule